// File: doc/BRIEF.md
# Memory-Indirect Address Sequencer

This block works out a full-format effective address from four parts: a base (the program counter or an address register), an index register, a base displacement and an outer displacement. Any part can be suppressed on its own, and a suppressed part counts as zero. The index is sign-extended or taken whole, depending on its size select, and is then scaled by 1, 2, 4 or 8. Word displacements are sign-extended to 32 bits.

Without memory indirection the block adds base, base displacement and scaled index and makes no memory access. In the memory-indirect forms it first reads a 32-bit pointer over a request/acknowledge port and then adds the outer displacement to it. The index goes in before the read (preindexed), after the read (postindexed), or not at all (index-suppressed form). Decoding of the extension words happens upstream. All control fields arrive already decoded, together with the operand values. They are latched when `start` is seen in IDLE.

The sequencer has five states. IDLE waits for `start` and latches the operands. CALC forms the first sum. It goes to DONE on an all-suppressed error or in the direct mode, and to READ otherwise. READ holds the request until acknowledge (on to FINAL) or bus error (on to DONE). FINAL forms the second sum and goes to DONE. DONE raises a one-cycle `done` or `err` and returns to IDLE.

Top module: `mind_addr_seq`

## Requirements
- R1: A part whose suppress input is 1 contributes zero to every sum it would enter.
- R2: When `base_is_pc`=1 the base is `pc_value`, otherwise `areg_value`.
- R3: With `idx_long`=0 the index is bits 15:0 of `idx_value` sign-extended, with `idx_long`=1 all 32 bits. It is then shifted left by `idx_scale` (0..3, giving factors 1, 2, 4 and 8).
- R4: With `bd_long`/`od_long`=0 the displacement is bits 15:0 sign-extended, with 1 all 32 bits.
- R5: With `ind_mode`=0 (direct), `addr_out` = base + bd + scaled index. The outer displacement is ignored, no memory request is made, and `done` is high exactly 2 cycles after the cycle in which `start` is sampled.
- R6: With `ind_mode`=1 (preindexed), the read goes to base + bd + scaled index, and `addr_out` = read data + od.
- R7: With `ind_mode`=2 (postindexed), the read goes to base + bd, and `addr_out` = read data + scaled index + od.
- R8: With `ind_mode`=3 (index-suppressed indirect), the read goes to base + bd and `addr_out` = read data + od. The index is ignored whatever `idx_sup` says.
- R9: If every part that counts is suppressed, the block pulses `err` 2 cycles after start, with no `done` and no memory request. The parts that count are base, index and bd, plus od in the indirect modes, and in mode 3 the index always counts as suppressed.
- R10: A `mem_err` sampled during a request ends the sequence with an `err` pulse, and no `done` is given.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack` or `mem_err`. An indirect operation whose acknowledge comes after d wait cycles reports `done` 4+d cycles after start.
- R12: `done` and `err` are single-cycle pulses. A `start` seen outside IDLE is ignored, and so are operand changes after the start has been latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (taken in IDLE only) |
| ind_mode | input | 2 | 0 direct, 1 preindexed, 2 postindexed, 3 index-suppressed indirect |
| base_is_pc | input | 1 | Select program counter as base |
| pc_value | input | 32 | Program counter (extension word address) |
| areg_value | input | 32 | Selected address register |
| base_sup | input | 1 | Suppress base |
| idx_value | input | 32 | Index register contents |
| idx_long | input | 1 | Index size: 1 long, 0 word |
| idx_scale | input | 2 | Index shift amount |
| idx_sup | input | 1 | Suppress index |
| bd_value | input | 32 | Base displacement |
| bd_long | input | 1 | Base displacement size: 1 long, 0 word |
| bd_sup | input | 1 | Suppress base displacement |
| od_value | input | 32 | Outer displacement |
| od_long | input | 1 | Outer displacement size: 1 long, 0 word |
| od_sup | input | 1 | Suppress outer displacement |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Bus error for the pending read |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | One-cycle error strobe |
| addr_out | output | 32 | Final effective address |

## Verification
The assertions check, on every cycle, the protocol and sequencing rules. A pending request keeps its address, the direct mode never requests memory, an all-suppressed operand set and a bus error each end in `err` without `done`, FINAL is always followed by `done`, and a strobe never lasts two cycles. The arithmetic can only be shown by the bench's scenarios, which compare against expected values computed from the requirements. That covers sign extension, scaling, base selection, where the index enters in each indirect mode, the latencies under different acknowledge delays, and the ignoring of `start` and operand changes while busy.

// File: rtl/mind_pkg.sv
package mind_pkg;
    localparam int ADDR_W  = 32;
    localparam int HALF_W  = 16;
    localparam int SCALE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CALC  = 3'd1,
        ST_READ  = 3'd2,
        ST_FINAL = 3'd3,
        ST_DONE  = 3'd4
    } mind_state_e;

    typedef enum logic [1:0] {
        IND_NONE  = 2'd0,
        IND_PRE   = 2'd1,
        IND_POST  = 2'd2,
        IND_NOIDX = 2'd3
    } mind_ind_e;
endpackage

// File: rtl/mind_sext.sv
module mind_sext #(
    parameter int AW = mind_pkg::ADDR_W,
    parameter int HW = mind_pkg::HALF_W
) (
    input  logic [AW-1:0] raw,
    input  logic          is_long,
    input  logic          sup,
    output logic [AW-1:0] ext
);
    localparam int PAD_W = AW - HW;

    always_comb begin
        if (sup) begin
            ext = '0;
        end else if (is_long) begin
            ext = raw;
        end else begin
            ext = {{PAD_W{raw[HW-1]}}, raw[HW-1:0]};
        end
    end
endmodule

// File: rtl/mind_idx_scale.sv
module mind_idx_scale #(
    parameter int AW = mind_pkg::ADDR_W,
    parameter int SW = mind_pkg::SCALE_W
) (
    input  logic [AW-1:0] idx_in,
    input  logic [SW-1:0] shamt,
    output logic [AW-1:0] idx_out
);
    always_comb begin
        idx_out = idx_in << shamt;
    end
endmodule

// File: rtl/mind_adder3.sv
module mind_adder3 #(
    parameter int AW = mind_pkg::ADDR_W
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [AW-1:0] sum
);
    always_comb begin
        sum = a + b + c;
    end
endmodule

// File: rtl/mind_addr_seq.sv
module mind_addr_seq
    import mind_pkg::*;
#(
    parameter int AW = mind_pkg::ADDR_W,
    parameter int HW = mind_pkg::HALF_W,
    parameter int SW = mind_pkg::SCALE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    ind_mode,
    input  logic          base_is_pc,
    input  logic [AW-1:0] pc_value,
    input  logic [AW-1:0] areg_value,
    input  logic          base_sup,
    input  logic [AW-1:0] idx_value,
    input  logic          idx_long,
    input  logic [SW-1:0] idx_scale,
    input  logic          idx_sup,
    input  logic [AW-1:0] bd_value,
    input  logic          bd_long,
    input  logic          bd_sup,
    input  logic [AW-1:0] od_value,
    input  logic          od_long,
    input  logic          od_sup,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] addr_out
);
    mind_state_e state_q, state_d;
    mind_ind_e   mode_q;

    logic          base_pc_q, base_sup_q;
    logic [AW-1:0] pc_q, areg_q;
    logic [AW-1:0] idx_q, bd_q, od_q;
    logic          idx_long_q, idx_sup_q, bd_long_q, bd_sup_q, od_long_q, od_sup_q;
    logic [SW-1:0] scale_q;
    logic [AW-1:0] ptr_q, rdata_q, result_q;
    logic          err_q;

    logic          idx_eff_sup, all_sup;
    logic [AW-1:0] base_sel, idx_ext, idx_scaled, bd_ext, od_ext;
    logic [AW-1:0] add_a, add_b, add_c, add_sum;

    // ---------------- operand preparation ----------------
    assign idx_eff_sup = idx_sup_q | (mode_q == IND_NOIDX);

    always_comb begin
        if (base_sup_q) begin
            base_sel = '0;
        end else if (base_pc_q) begin
            base_sel = pc_q;
        end else begin
            base_sel = areg_q;
        end
    end

    mind_sext #(.AW(AW), .HW(HW)) u_idx_ext (
        .raw(idx_q), .is_long(idx_long_q), .sup(idx_eff_sup), .ext(idx_ext)
    );
    mind_idx_scale #(.AW(AW), .SW(SW)) u_idx_scale (
        .idx_in(idx_ext), .shamt(scale_q), .idx_out(idx_scaled)
    );
    mind_sext #(.AW(AW), .HW(HW)) u_bd_ext (
        .raw(bd_q), .is_long(bd_long_q), .sup(bd_sup_q), .ext(bd_ext)
    );
    mind_sext #(.AW(AW), .HW(HW)) u_od_ext (
        .raw(od_q), .is_long(od_long_q), .sup(od_sup_q), .ext(od_ext)
    );

    always_comb begin
        all_sup = base_sup_q & idx_eff_sup & bd_sup_q &
                  (od_sup_q | (mode_q == IND_NONE));
    end

    // ---------------- shared three-input adder ----------------
    always_comb begin
        if (state_q == ST_FINAL) begin
            add_a = rdata_q;
            add_b = od_ext;
            add_c = (mode_q == IND_POST) ? idx_scaled : '0;
        end else begin
            add_a = base_sel;
            add_b = bd_ext;
            add_c = (mode_q == IND_NONE || mode_q == IND_PRE) ? idx_scaled : '0;
        end
    end

    mind_adder3 #(.AW(AW)) u_add (
        .a(add_a), .b(add_b), .c(add_c), .sum(add_sum)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CALC;
            end
            ST_CALC: begin
                if (all_sup || mode_q == IND_NONE) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_err) begin
                    state_d = ST_DONE;
                end else if (mem_ack) begin
                    state_d = ST_FINAL;
                end
            end
            ST_FINAL: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= IND_NONE;
            base_pc_q  <= 1'b0;
            base_sup_q <= 1'b0;
            pc_q       <= '0;
            areg_q     <= '0;
            idx_q      <= '0;
            idx_long_q <= 1'b0;
            idx_sup_q  <= 1'b0;
            scale_q    <= '0;
            bd_q       <= '0;
            bd_long_q  <= 1'b0;
            bd_sup_q   <= 1'b0;
            od_q       <= '0;
            od_long_q  <= 1'b0;
            od_sup_q   <= 1'b0;
            ptr_q      <= '0;
            rdata_q    <= '0;
            result_q   <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q     <= mind_ind_e'(ind_mode);
                        base_pc_q  <= base_is_pc;
                        base_sup_q <= base_sup;
                        pc_q       <= pc_value;
                        areg_q     <= areg_value;
                        idx_q      <= idx_value;
                        idx_long_q <= idx_long;
                        idx_sup_q  <= idx_sup;
                        scale_q    <= idx_scale;
                        bd_q       <= bd_value;
                        bd_long_q  <= bd_long;
                        bd_sup_q   <= bd_sup;
                        od_q       <= od_value;
                        od_long_q  <= od_long;
                        od_sup_q   <= od_sup;
                        err_q      <= 1'b0;
                    end
                end
                ST_CALC: begin
                    if (all_sup) begin
                        err_q <= 1'b1;
                    end else if (mode_q == IND_NONE) begin
                        result_q <= add_sum;
                    end else begin
                        ptr_q <= add_sum;
                    end
                end
                ST_READ: begin
                    if (mem_err) begin
                        err_q <= 1'b1;
                    end else if (mem_ack) begin
                        rdata_q <= mem_rdata;
                    end
                end
                ST_FINAL: begin
                    result_q <= add_sum;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req  = (state_q == ST_READ);
        mem_addr = ptr_q;
        done     = (state_q == ST_DONE) && !err_q;
        err      = (state_q == ST_DONE) && err_q;
        addr_out = result_q;
    end

    // ---------------- assertions ----------------
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));

    // R5
    direct_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && mode_q == IND_NONE) |=> !mem_req);

    // R9
    allsup_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && all_sup) |=> (err && !done && !mem_req));

    // R10
    bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (err && !done));

    // R11
    final_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINAL) |=> done);
endmodule

// File: tb/mind_addr_seq_tb.sv
module mind_addr_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  ind_mode = '0;
    logic        base_is_pc = 1'b0;
    logic [31:0] pc_value = '0, areg_value = '0;
    logic        base_sup = 1'b0;
    logic [31:0] idx_value = '0;
    logic        idx_long = 1'b0;
    logic [1:0]  idx_scale = '0;
    logic        idx_sup = 1'b0;
    logic [31:0] bd_value = '0;
    logic        bd_long = 1'b0, bd_sup = 1'b0;
    logic [31:0] od_value = '0;
    logic        od_long = 1'b0, od_sup = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        done, err;
    logic [31:0] addr_out;

    int total = 0;
    int bad = 0;
    int mem_delay = 0;
    int wait_cnt = 0;
    bit err_inject = 0;
    bit poke_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mind_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ind_mode(ind_mode),
        .base_is_pc(base_is_pc), .pc_value(pc_value), .areg_value(areg_value),
        .base_sup(base_sup), .idx_value(idx_value), .idx_long(idx_long),
        .idx_scale(idx_scale), .idx_sup(idx_sup), .bd_value(bd_value),
        .bd_long(bd_long), .bd_sup(bd_sup), .od_value(od_value),
        .od_long(od_long), .od_sup(od_sup), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .done(done), .err(err), .addr_out(addr_out)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C96_A5E1;
    endfunction

    function automatic logic [31:0] ext16(input logic [31:0] v, input logic lng, input logic sup);
        if (sup) return 32'h0;
        if (lng) return v;
        return {{16{v[15]}}, v[15:0]};
    endfunction

    // memory responder
    always @(negedge clk) begin
        if (mem_req && !mem_ack && !mem_err) begin
            if (wait_cnt >= mem_delay) begin
                mem_ack   = !err_inject;
                mem_err   = err_inject;
                mem_rdata = err_inject ? 32'hDEAD_0000 : mem_word(mem_addr);
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag);
        logic [31:0] base, idx_s, bd, od, ptr, res, first_addr;
        bit all_sup, exp_err, saw_req, addr_moved, got_done, got_err;
        int exp_lat, lat, extra;
        base    = base_sup ? 32'h0 : (base_is_pc ? pc_value : areg_value);
        idx_s   = ext16(idx_value, idx_long, idx_sup || ind_mode == 2'd3) << idx_scale;
        bd      = ext16(bd_value, bd_long, bd_sup);
        od      = ext16(od_value, od_long, od_sup);
        all_sup = base_sup && (idx_sup || ind_mode == 2'd3) && bd_sup &&
                  (od_sup || ind_mode == 2'd0);
        ptr     = base + bd + ((ind_mode <= 2'd1) ? idx_s : 32'h0);
        res     = (ind_mode == 2'd0) ? ptr :
                  mem_word(ptr) + od + ((ind_mode == 2'd2) ? idx_s : 32'h0);
        exp_err = all_sup || (err_inject && ind_mode != 2'd0);
        if (all_sup || ind_mode == 2'd0) exp_lat = 2;
        else if (err_inject) exp_lat = 3 + mem_delay;
        else exp_lat = 4 + mem_delay;

        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        saw_req = 0; addr_moved = 0; first_addr = '0; lat = 0;
        for (int c = 1; c < 100; c++) begin
            if (done || err) begin
                lat = c;
                break;
            end
            if (mem_req) begin
                if (!saw_req) first_addr = mem_addr;
                else if (mem_addr != first_addr) addr_moved = 1;
                saw_req = 1;
            end
            if (poke_busy && c == 1) begin
                start = 1'b1;
                idx_value = ~idx_value;
                bd_value  = bd_value + 32'h1234;
                od_value  = ~od_value;
                ind_mode  = ind_mode ^ 2'd1;
            end
            if (poke_busy && c == 2) start = 1'b0;
            @(negedge clk);
        end
        got_done = done;
        got_err  = err;
        chk(lat != 0, tag, "completion", 32'(lat), 32'(exp_lat));
        chk(got_err == exp_err && got_done == !exp_err, tag, "outcome err/done",
            {30'h0, got_err, got_done}, {30'h0, exp_err, !exp_err});
        chk(lat == exp_lat, tag, "latency", 32'(lat), 32'(exp_lat));
        if (!exp_err)
            chk(addr_out == res, tag, "addr_out", addr_out, res);
        if (ind_mode == 2'd0 || all_sup)
            chk(!saw_req, tag, "no memory request", {31'h0, saw_req}, 32'h0);
        else
            chk(saw_req && first_addr == ptr && !addr_moved, tag, "pointer address",
                first_addr, ptr);
        extra = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done || err) extra++;
        end
        // R12: strobe lasts one cycle and no stray operation follows
        chk(extra == 0, tag, "R12 no repeat strobe", 32'(extra), 32'h0);
    endtask

    task automatic clear_ops();
        ind_mode = 2'd0; base_is_pc = 0; base_sup = 0; idx_sup = 0; bd_sup = 0;
        od_sup = 0; idx_long = 1; bd_long = 1; od_long = 1; idx_scale = 0;
        pc_value = 32'h0001_0000; areg_value = 32'h0020_0000;
        idx_value = 32'h10; bd_value = 32'h100; od_value = 32'h4;
        err_inject = 0; mem_delay = 0; poke_busy = 0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_ops();
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_req, "R12", "reset outputs idle",
            {29'h0, done, err, mem_req}, 32'h0);
        rst_n = 1'b1;

        // R2 base select and R5 direct mode (od ignored)
        base_is_pc = 1; od_value = 32'hFFFF_FFFF;
        run_op("R2/R5 pc base");
        base_is_pc = 0;
        run_op("R2/R5 areg base");

        // R3 word index negative, every scale factor
        for (int s = 0; s < 4; s++) begin
            idx_long = 0; idx_value = 32'h7777_8001; idx_scale = 2'(s);
            run_op("R3 word index scale");
        end
        idx_long = 1; idx_scale = 2'd3; idx_value = 32'h0001_0003;
        run_op("R3 long index");

        // R4 word displacements negative, R6 preindexed
        clear_ops(); ind_mode = 2'd1;
        bd_long = 0; bd_value = 32'h1234_FFF0; od_long = 0; od_value = 32'h0000_8000;
        run_op("R4/R6 preindexed word disps");

        // R7 postindexed
        clear_ops(); ind_mode = 2'd2; idx_scale = 2'd2;
        run_op("R7 postindexed");

        // R8 index-suppressed indirect, index nonzero and enabled
        clear_ops(); ind_mode = 2'd3; idx_value = 32'h0F0F_0000;
        run_op("R8 index suppressed mode");

        // R1 suppression of each part
        clear_ops(); base_sup = 1; run_op("R1 base suppressed");
        clear_ops(); ind_mode = 2'd1; bd_sup = 1; od_sup = 1; run_op("R1 bd/od suppressed");

        // R9 all suppressed (direct: od active but does not count)
        clear_ops(); base_sup = 1; idx_sup = 1; bd_sup = 1;
        run_op("R9 direct all suppressed");
        ind_mode = 2'd1; od_sup = 1;
        run_op("R9 indirect all suppressed");
        ind_mode = 2'd3; idx_sup = 0; od_sup = 1;
        run_op("R9 mode3 index counts suppressed");

        // R10 bus error
        clear_ops(); ind_mode = 2'd2; err_inject = 1; mem_delay = 2;
        run_op("R10 bus error");

        // R11 long acknowledge wait
        clear_ops(); ind_mode = 2'd1; mem_delay = 5;
        run_op("R11 slow acknowledge");

        // R12 start and operand changes while busy
        clear_ops(); ind_mode = 2'd2; mem_delay = 1; poke_busy = 1;
        run_op("R12 start while busy");
        poke_busy = 0;

        // random mix
        for (int n = 0; n < 300; n++) begin
            ind_mode   = 2'($urandom_range(3));
            base_is_pc = 1'($urandom_range(1));
            pc_value   = $urandom; areg_value = $urandom;
            idx_value  = $urandom; bd_value = $urandom; od_value = $urandom;
            idx_long   = 1'($urandom_range(1)); bd_long = 1'($urandom_range(1));
            od_long    = 1'($urandom_range(1)); idx_scale = 2'($urandom_range(3));
            base_sup   = ($urandom_range(3) == 0); idx_sup = ($urandom_range(3) == 0);
            bd_sup     = ($urandom_range(3) == 0); od_sup = ($urandom_range(3) == 0);
            mem_delay  = $urandom_range(3);
            err_inject = ($urandom_range(15) == 0);
            run_op("R1/R3/R4/R6/R7/R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule